// File: doc/BRIEF.md
# Banked Interrupt Request Aggregator

The block gathers 24 interrupt request lines into three byte-wide banks. Each bank has a status register and a mask register, reached over a simple byte bus with an address, a read strobe, a write strobe and write data. Each request line passes through a two-flop synchronizer. One designated line is level-sensitive and all the others are edge-captured. One combined interrupt line goes to the host, which watches it for rising edges and then reads the status registers to find the sources.

Edge-captured sources latch a pending bit on a rising edge, but only while their mask bit enables them. An edge seen while the source is masked is dropped for good. Reading a bank's status register clears that bank's edge-captured pending bits, so no acknowledge write exists. The level-sensitive source shows its synchronized input, gated by its mask, and reads do not touch it. The combined output is registered. It falls after a read leaves nothing enabled and pending, so the next event gives the host a fresh rising edge.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every mask bit is 0, every status register reads 0, and `irq_out` is 0.
- R2: Address 2b reads the status of bank b and address 2b+1 holds the mask of bank b (b = 0, 1, 2). A write to a mask address loads `reg_wdata`, and a read returns it. A read of addresses 6 or 7 returns 0. Read data appears on `reg_rdata` in the cycle after the read strobe and is 0 in any cycle that follows no read.
- R3: Source s maps to bank s/8, bit s%8. A rising edge on an enabled edge-captured source sets its status bit. The bit can be read starting three clock edges after the input changes.
- R4: A rising edge that arrives while its mask bit is 0 is not latched. Unmasking the source later neither sets its status bit nor raises `irq_out`.
- R5: A status read returns the bank's current status. At the same edge it clears every edge-captured pending bit of that bank.
- R6: The level-sensitive source's status bit equals its synchronized input AND its mask bit. A status read does not clear it.
- R7: If a source's captured edge falls on the same clock edge as a status read of its bank, the pending bit stays set. A following read returns it.
- R8: `irq_out` is the registered OR over all banks of status AND mask. It returns to 0 in the cycle after a read clears the last enabled pending bit.
- R9: A request input held high sets its pending bit only once. After a clearing read it stays clear until the input falls and rises again.
- R10: The level-sensitive source is set by the `LEVEL_SRC` parameter, which defaults to source 10 (bank 1, bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 24 | Asynchronous interrupt request lines |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
A request change is latched at the third rising edge after it, and `irq_out` follows one edge later. Read data and the clear-on-read both take effect at the edge that samples the strobe. The bench keeps a cycle-by-cycle reference model fed with the same stimulus. It compares `irq_out` and `reg_rdata` at every falling edge, so each result is checked in exactly the cycle it is due. Directed cases count edges explicitly, for example placing a read on the same edge as a captured rise, before long random traffic.

// File: rtl/irq_agg_pkg.sv
// Shared types for the banked interrupt aggregator.
// Assumes: register address bit 0 selects status (0) or mask (1).
package irq_agg_pkg;
    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_MASK   = 1'b1
    } reg_kind_e;
endpackage

// File: rtl/irq_agg_sync.sv
// Two-flop synchronizer with one extra history stage for rising-edge detection.
// Assumes: request lines are asynchronous; a rise is reported for one cycle.
module irq_agg_sync #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] lvl_out,
    output logic [WIDTH-1:0] rise_out
);
    logic [WIDTH-1:0] meta_q, sync_q, hist_q;

    // Purpose: bring requests into the clock domain and keep last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign lvl_out  = sync_q;
    assign rise_out = sync_q & ~hist_q;

    // R9: a held-high input reports its rise only once
    a_r9_one_cycle_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_out != '0) |=> ((rise_out & $past(rise_out)) == '0));
endmodule

// File: rtl/irq_agg_bank.sv
// One byte-wide bank: mask register, edge pending latches, clear-on-read.
// Assumes: LEVEL_BIT selects the one live level bit of this bank, -1 for none.
module irq_agg_bank #(
    parameter int BANK_W    = 8,
    parameter int LEVEL_BIT = -1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lvl_in,
    input  logic [BANK_W-1:0] rise_in,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic              stat_rd,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] active
);
    localparam int LVL_SHIFT = (LEVEL_BIT >= 0) ? LEVEL_BIT : 0;
    localparam logic [BANK_W-1:0] LVL_ONEHOT =
        (LEVEL_BIT >= 0) ? (BANK_W'(1) << LVL_SHIFT) : '0;
    localparam logic [BANK_W-1:0] EDGE_BITS = ~LVL_ONEHOT;

    logic [BANK_W-1:0] pend_q, capture, clr;

    // Purpose: hold the enable mask written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Purpose: a rise latches only while enabled; a read clears, a rise wins.
    assign capture = rise_in & mask_q & EDGE_BITS;
    assign clr     = stat_rd ? EDGE_BITS : '0;

    // Purpose: edge pending latches.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | capture;
    end

    assign status = pend_q | (lvl_in & mask_q & LVL_ONEHOT);
    assign active = status & mask_q;

    // R2: a mask write loads the data
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wdata)));
    // R4: no pending bit appears for a source that was masked
    a_r4_masked_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));
    // R5: a read with no simultaneous rise leaves no edge pending bit
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ((rise_in & mask_q & EDGE_BITS) == '0)) |=> ((pend_q & EDGE_BITS) == '0));
    // R7: a rise on the read edge survives the read
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((pend_q & $past(rise_in & mask_q & EDGE_BITS)) == $past(rise_in & mask_q & EDGE_BITS)));
endmodule

// File: rtl/irq_aggregator.sv
// Top: synchronizes 24 requests, builds three banks, decodes the byte bus,
// registers read data and the combined interrupt.
// Assumes: one read strobe per read; reg_rd and reg_wr not asserted together.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter  int NUM_BANKS = 3,
    parameter  int BANK_W    = 8,
    parameter  int LEVEL_SRC = 10,
    localparam int NUM_SRC   = NUM_BANKS * BANK_W,
    localparam int ADDR_W    = $clog2(2 * NUM_BANKS),
    localparam int BSEL_W    = ADDR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [BANK_W-1:0]  reg_wdata,
    output logic [BANK_W-1:0]  reg_rdata,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] req_lvl, req_rise;
    logic [BSEL_W-1:0]  sel_bank;
    reg_kind_e          sel_kind;
    logic               sel_ok;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_status, bank_mask, bank_active;
    logic [BANK_W-1:0]  rd_word;
    logic               any_active;
    logic [BANK_W-1:0]  rdata_q;
    logic               irq_q;

    irq_agg_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (irq_req),
        .lvl_out  (req_lvl),
        .rise_out (req_rise)
    );

    // Purpose: split the address into bank and register kind.
    assign sel_bank = reg_addr[ADDR_W-1:1];
    assign sel_kind = reg_kind_e'(reg_addr[0]);
    assign sel_ok   = (int'(sel_bank) < NUM_BANKS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LVL_BIT = ((LEVEL_SRC / BANK_W) == b) ? (LEVEL_SRC % BANK_W) : -1;
        irq_agg_bank #(.BANK_W(BANK_W), .LEVEL_BIT(LVL_BIT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_in  (req_lvl[b*BANK_W +: BANK_W]),
            .rise_in (req_rise[b*BANK_W +: BANK_W]),
            .mask_we (reg_wr && sel_ok && sel_kind == REG_MASK && sel_bank == BSEL_W'(b)),
            .wdata   (reg_wdata),
            .stat_rd (reg_rd && sel_ok && sel_kind == REG_STATUS && sel_bank == BSEL_W'(b)),
            .mask_q  (bank_mask[b]),
            .status  (bank_status[b]),
            .active  (bank_active[b])
        );
    end

    // Purpose: select the addressed register; unmapped addresses read 0.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_bank == BSEL_W'(b))
                rd_word = (sel_kind == REG_MASK) ? bank_mask[b] : bank_status[b];
        end
    end

    assign any_active = |bank_active;

    // Purpose: register read data and the combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            rdata_q <= reg_rd ? rd_word : '0;
            irq_q   <= any_active;
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_out   = irq_q;

    // R8: output rises after enabled pending work exists
    a_r8_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |=> irq_out);
    // R8: output drops once nothing enabled is pending
    a_r8_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !any_active |=> !irq_out);
    // R2: unmapped reads return zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !sel_ok) |=> (reg_rdata == '0));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    localparam int NS = 24;
    localparam int LV = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic [2:0] reg_addr = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_out;

    int checks = 0;
    int fails = 0;
    bit cmp_en = 1'b0;

    always #2 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // Reference model built from the requirements
    logic [NS-1:0] m_s1, m_s2, m_prev, m_pend, m_mask;
    logic [7:0] m_rdata;
    logic m_irq;
    logic [NS-1:0] t_st, t_clr, t_rise, t_mask;

    function automatic logic [NS-1:0] f_status(input logic [NS-1:0] pend, s2, mask);
        return pend | (s2 & mask & (NS'(1) << LV));
    endfunction

    function automatic logic [7:0] f_read(input logic [2:0] a, input logic [NS-1:0] st, mask);
        if (a[2:1] > 2'd2) return 8'h00;
        return a[0] ? 8'(mask >> (8 * a[2:1])) : 8'(st >> (8 * a[2:1]));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_mask <= '0;
            m_rdata <= '0; m_irq <= 1'b0;
        end else begin
            t_st   = f_status(m_pend, m_s2, m_mask);
            t_rise = m_s2 & ~m_prev;
            t_clr  = '0;
            if (reg_rd && !reg_addr[0] && reg_addr[2:1] <= 2'd2)
                t_clr = NS'(24'hFF) << (8 * reg_addr[2:1]);
            t_mask = m_mask;
            if (reg_wr && reg_addr[0] && reg_addr[2:1] <= 2'd2)
                t_mask[8*reg_addr[2:1] +: 8] = reg_wdata;
            m_pend  <= ((m_pend & ~t_clr) | (t_rise & m_mask)) & ~(NS'(1) << LV);
            m_mask  <= t_mask;
            m_rdata <= reg_rd ? f_read(reg_addr, t_st, m_mask) : 8'h00;
            m_irq   <= |(t_st & m_mask);
            m_s1 <= irq_req; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one cycle; compare the model at the falling edge
    task automatic tick();
        @(negedge clk);
        if (cmp_en) begin
            chk(irq_out === m_irq, "R8 model irq_out", 32'(irq_out), 32'(m_irq));
            chk(reg_rdata === m_rdata, "R5 model rdata", 32'(reg_rdata), 32'(m_rdata));
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    initial begin
        #400000;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd12345));
        wait_n(4);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        tick();
        // R1 reset state
        chk(irq_out == 1'b0, "R1 irq_out", 32'(irq_out), 0);
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), d);
            chk(d == 8'h00, "R1 register", 32'(d), 0);
        end
        // R2 mask write/readback and unmapped read
        for (int b = 0; b < 3; b++) bus_write(3'(2*b+1), 8'hFF);
        bus_read(3'd3, d);
        chk(d == 8'hFF, "R2 mask readback", 32'(d), 32'hFF);
        bus_read(3'd6, d);
        chk(d == 8'h00, "R2 unmapped", 32'(d), 0);
        // R3 edge capture on source 3
        irq_req[3] = 1'b1;
        wait_n(4);
        chk(irq_out == 1'b1, "R8 irq raised", 32'(irq_out), 1);
        bus_read(3'd0, d);
        chk(d == 8'h08, "R3 status bit", 32'(d), 32'h08);
        bus_read(3'd0, d);
        chk(d == 8'h00, "R5 cleared by read", 32'(d), 0);
        chk(irq_out == 1'b0, "R8 irq dropped", 32'(irq_out), 0);
        wait_n(5);
        bus_read(3'd0, d);
        chk(d == 8'h00, "R9 held input no recapture", 32'(d), 0);
        irq_req[3] = 1'b0;
        // R4 masked edge lost (source 16)
        bus_write(3'd5, 8'hFE);
        irq_req[16] = 1'b1;
        wait_n(5);
        bus_write(3'd5, 8'hFF);
        wait_n(5);
        chk(irq_out == 1'b0, "R4 no irq after unmask", 32'(irq_out), 0);
        bus_read(3'd4, d);
        chk(d == 8'h00, "R4 status after unmask", 32'(d), 0);
        // R6 / R10 level source 10 = bank 1 bit 2
        irq_req[LV] = 1'b1;
        wait_n(4);
        bus_read(3'd2, d);
        chk(d == 8'h04, "R10 level bit position", 32'(d), 32'h04);
        bus_read(3'd2, d);
        chk(d == 8'h04, "R6 level survives read", 32'(d), 32'h04);
        chk(irq_out == 1'b1, "R6 irq with level", 32'(irq_out), 1);
        irq_req[LV] = 1'b0;
        wait_n(2);
        bus_read(3'd2, d);
        chk(d == 8'h00, "R6 level follows input", 32'(d), 0);
        wait_n(2);
        chk(irq_out == 1'b0, "R8 idle after level low", 32'(irq_out), 0);
        // R7 edge on the read edge wins (sources 8 and 9)
        irq_req[8] = 1'b1;
        wait_n(4);
        irq_req[9] = 1'b1;
        wait_n(2);
        bus_read(3'd2, d);
        chk(d == 8'h01, "R7 read before edge", 32'(d), 32'h01);
        bus_read(3'd2, d);
        chk(d == 8'h02, "R7 edge survived read", 32'(d), 32'h02);
        irq_req = '0;
        wait_n(4);
        // Random traffic against the model
        for (int it = 0; it < 4000; it++) begin
            if ($urandom_range(0, 5) == 0) irq_req ^= NS'(1) << $urandom_range(0, NS-1);
            case ($urandom_range(0, 3))
                0: begin reg_rd = 1'b1; reg_addr = 3'($urandom_range(0, 7)); end
                1: begin
                    reg_wr = 1'b1;
                    reg_addr = {2'($urandom_range(0, 3)), 1'b1};
                    reg_wdata = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'hFF;
                end
                default: ;
            endcase
            tick();
            reg_rd = 1'b0; reg_wr = 1'b0;
        end
        wait_n(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule